// File: doc/BRIEF.md
# Watchdog Timer with Halt and Wake Controller

This block pairs a watchdog counter with a small power-mode controller. It runs on a free-running master clock. Each clock source reaches it as a single-cycle tick strobe: the dedicated watchdog oscillator, the real-time clock, or the instruction clock. A static option picks one of the three strobes, and a second static option switches the watchdog off. The counter is a prescaler and a main counter chained into one register of `PRE_W + CNT_W` bits. It overflows after exactly 2^(PRE_W+CNT_W) selected ticks since it was last cleared.

Software clears the counter with commands. A static option selects how: either one clear command is enough, or two distinct commands (A and B) must both be seen before the counter clears. When the watchdog overflows, the result depends on the power mode. In run mode it asks for a full chip reset. While halted it asks for a warm reset, which restarts only the program counter and the stack pointer, and it also ends the halt.

A halt request stops the system clock enable. It clears the counter, sets the power-down flag and clears the timeout flag. Halt ends on an interrupt, on a falling edge at any enabled wake pin, on a watchdog overflow, or on external reset. Because the instruction clock stops with the system clock, that source delivers no ticks while halted. The other two sources keep counting.

Top module: `wdt_pwr_ctrl`

## Requirements
- R1: The counter advances only on the tick of the source chosen by `cfg_src`: 0 = watchdog oscillator, 1 = real-time clock, 2 = instruction clock, 3 = no source (the counter never advances).
- R2: With `cfg_wdt_en` low the counter is held at zero, and `wdt_ovf`, `chip_rst` and `warm_rst` never assert.
- R3: The counter overflows on the 2^(PRE_W+CNT_W)-th selected tick after reset or after the last clear. `wdt_ovf` is then high for exactly one cycle, in the cycle after that tick's clock edge, and counting wraps to zero.
- R4: With `cfg_pair_mode` low, `clr_single` clears the counter, and `clr_a` / `clr_b` have no effect.
- R5: With `cfg_pair_mode` high, the counter clears in the cycle where both `clr_a` and `clr_b` have been seen, in any order or together. The record of seen commands is then emptied, so repeating either command alone does not clear. `clr_single` has no effect.
- R6: `halt_req` while running sets `halted` from the next cycle and clears the counter. It also sets `pd_flag` and clears `to_flag`. `halt_req` while already halted is ignored.
- R7: `sys_clk_en` is low exactly while halted. Instruction-clock ticks are ignored while halted, and the other two sources keep counting.
- R8: An overflow while running produces a one-cycle `chip_rst` pulse together with `wdt_ovf`. It sets `to_flag`, clears `pd_flag` and never asserts `warm_rst`.
- R9: An overflow while halted produces a one-cycle `warm_rst` pulse with no `chip_rst`. It sets `to_flag`, leaves `pd_flag` set and clears `halted`.
- R10: While halted, `irq` high or a high-to-low transition on any wake pin whose `wake_en` bit is set clears `halted` in the next cycle. Transitions on pins that are not enabled are ignored.
- R11: While `rst_n` is low and after it is released, the outputs read `halted`=0, `pd_flag`=0, `to_flag`=0, pulses=0 and `sys_clk_en`=1. The wake pins' previous level is taken as high.
- R12: A clear in the same cycle as the final tick wins: no overflow occurs, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst_n | input | 1 | External reset, active low |
| cfg_src | input | 2 | Static tick source select (R1 encoding) |
| cfg_wdt_en | input | 1 | Static watchdog enable |
| cfg_pair_mode | input | 1 | Static clear mode: 1 = two-command pair |
| osc_tick | input | 1 | Watchdog oscillator tick strobe |
| rtc_tick | input | 1 | Real-time clock tick strobe |
| instr_tick | input | 1 | Instruction clock tick strobe |
| clr_single | input | 1 | Single clear command |
| clr_a | input | 1 | First command of the clear pair |
| clr_b | input | 1 | Second command of the clear pair |
| halt_req | input | 1 | Halt instruction executed |
| irq | input | 1 | Interrupt wake request |
| wake_pins | input | WAKE_N | Port pins usable as wake sources |
| wake_en | input | WAKE_N | Per-pin wake enable |
| sys_clk_en | output | 1 | System clock enable, low while halted |
| halted | output | 1 | Halt mode active |
| pd_flag | output | 1 | Power-down flag |
| to_flag | output | 1 | Timeout flag |
| wdt_ovf | output | 1 | One-cycle overflow pulse |
| chip_rst | output | 1 | Full chip reset request pulse |
| warm_rst | output | 1 | Warm reset request pulse (program counter and stack pointer) |

## Verification
The assertions check, on every cycle, that a halt entry produces the halted state with the right flags. They also check that a warm reset ends a halt, that the two reset pulses never coincide, and that a completed pair empties its record. They further check that the count is frozen for the instruction source while halted, and that a disabled watchdog stays silent. Only the bench's scenarios can show the exact overflow cycle counted in ticks, and that a repeated single pair command leaves the deadline unchanged. The same holds for a clear landing on the final tick suppressing the overflow, and for the interplay of random wake pins, interrupts and halts over long runs against an independent cycle model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SRC_OSC   = 2'd0,
    SRC_RTC   = 2'd1,
    SRC_INSTR = 2'd2,
    SRC_NONE  = 2'd3
  } wdt_src_e;
endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
  import wdt_pkg::*;
(
  input  wdt_src_e src,
  input  logic     osc_tick,
  input  logic     rtc_tick,
  input  logic     instr_tick,
  input  logic     halted,
  output logic     tick
);
  logic instr_live;
  assign instr_live = instr_tick & ~halted;

  always_comb begin
    unique case (src)
      SRC_OSC:   tick = osc_tick;
      SRC_RTC:   tick = rtc_tick;
      SRC_INSTR: tick = instr_live;
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pair_mode,
  input  logic clr_single,
  input  logic clr_a,
  input  logic clr_b,
  output logic cmd_clr,
  output logic pair_done
);
  logic seen_a, seen_b;

  assign pair_done = pair_mode & (seen_a | clr_a) & (seen_b | clr_b);
  assign cmd_clr   = pair_mode ? pair_done : clr_single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_a <= 1'b0;
      seen_b <= 1'b0;
    end else if (!pair_mode || pair_done) begin
      seen_a <= 1'b0;
      seen_b <= 1'b0;
    end else begin
      seen_a <= seen_a | clr_a;
      seen_b <= seen_b | clr_b;
    end
  end

  AST_PAIR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |=> (!seen_a && !seen_b)); // R5
  AST_PAIR_SINGLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_mode && clr_single && !clr_a && !clr_b && !seen_a && !seen_b) |-> !cmd_clr); // R5
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int PRE_W = 2,
  parameter int CNT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     tick,
  input  logic                     clr,
  output logic                     ovf,
  output logic [PRE_W+CNT_W-1:0]   count
);
  localparam int TOT_W = PRE_W + CNT_W;

  function automatic logic at_top(input logic [TOT_W-1:0] v);
    return &v;
  endfunction

  function automatic logic [TOT_W-1:0] bump(input logic [TOT_W-1:0] v);
    return v + {{(TOT_W-1){1'b0}}, 1'b1};
  endfunction

  assign ovf = en & ~clr & tick & at_top(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (!en || clr)   count <= '0;
    else if (tick)         count <= bump(count);
  end

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (count == '0)); // R3
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && tick) |=> (count == '0)); // R12
endmodule

// File: rtl/wdt_wake_det.sv
module wdt_wake_det #(
  parameter int WAKE_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAKE_N-1:0] pins,
  input  logic [WAKE_N-1:0] en,
  output logic              wake_hit
);
  logic [WAKE_N-1:0] prev;
  logic [WAKE_N-1:0] fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= pins;
  end

  for (genvar i = 0; i < WAKE_N; i++) begin : g_pin
    assign fall[i] = en[i] & prev[i] & ~pins[i];
  end

  assign wake_hit = |fall;
endmodule

// File: rtl/wdt_pwr_fsm.sv
module wdt_pwr_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic irq,
  input  logic wake_hit,
  input  logic ovf,
  output logic halt_enter,
  output logic halted,
  output logic pd_flag,
  output logic to_flag,
  output logic wdt_ovf,
  output logic chip_rst,
  output logic warm_rst
);
  logic wake_any;
  assign halt_enter = halt_req & ~halted;
  assign wake_any   = irq | wake_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted   <= 1'b0;
      pd_flag  <= 1'b0;
      to_flag  <= 1'b0;
      wdt_ovf  <= 1'b0;
      chip_rst <= 1'b0;
      warm_rst <= 1'b0;
    end else begin
      wdt_ovf  <= ovf;
      chip_rst <= ovf & ~halted;
      warm_rst <= ovf & halted;
      if (ovf) begin
        to_flag <= 1'b1;
        halted  <= 1'b0;
        if (!halted) pd_flag <= 1'b0;
      end else if (halted) begin
        if (wake_any) halted <= 1'b0;
      end else if (halt_enter) begin
        halted  <= 1'b1;
        pd_flag <= 1'b1;
        to_flag <= 1'b0;
      end
    end
  end

  AST_HALT_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    halt_enter |=> (halted && pd_flag && !to_flag)); // R6
  AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && wake_any) |=> !halted); // R10
  AST_RST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chip_rst, warm_rst})); // R8
  AST_WARM_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && halted) |=> (warm_rst && !halted && pd_flag && to_flag)); // R9
  AST_CHIP_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !halted) |=> (chip_rst && !pd_flag && to_flag)); // R8
endmodule

// File: rtl/wdt_pwr_ctrl.sv
module wdt_pwr_ctrl
  import wdt_pkg::*;
#(
  parameter int PRE_W  = 2,
  parameter int CNT_W  = 4,
  parameter int WAKE_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_src,
  input  logic              cfg_wdt_en,
  input  logic              cfg_pair_mode,
  input  logic              osc_tick,
  input  logic              rtc_tick,
  input  logic              instr_tick,
  input  logic              clr_single,
  input  logic              clr_a,
  input  logic              clr_b,
  input  logic              halt_req,
  input  logic              irq,
  input  logic [WAKE_N-1:0] wake_pins,
  input  logic [WAKE_N-1:0] wake_en,
  output logic              sys_clk_en,
  output logic              halted,
  output logic              pd_flag,
  output logic              to_flag,
  output logic              wdt_ovf,
  output logic              chip_rst,
  output logic              warm_rst
);
  localparam int TOT_W = PRE_W + CNT_W;

  wdt_src_e         src;
  logic             sel_tick;
  logic             cmd_clr;
  logic             pair_done;
  logic             halt_enter;
  logic             cnt_clr;
  logic             cnt_ovf;
  logic             wake_hit;
  logic [TOT_W-1:0] count;

  assign src        = wdt_src_e'(cfg_src);
  assign cnt_clr    = cmd_clr | halt_enter;
  assign sys_clk_en = ~halted;

  wdt_tick_sel u_sel (
    .src(src), .osc_tick(osc_tick), .rtc_tick(rtc_tick),
    .instr_tick(instr_tick), .halted(halted), .tick(sel_tick)
  );

  wdt_clear_ctl u_clr (
    .clk(clk), .rst_n(rst_n), .pair_mode(cfg_pair_mode),
    .clr_single(clr_single), .clr_a(clr_a), .clr_b(clr_b),
    .cmd_clr(cmd_clr), .pair_done(pair_done)
  );

  wdt_counter #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cfg_wdt_en), .tick(sel_tick),
    .clr(cnt_clr), .ovf(cnt_ovf), .count(count)
  );

  wdt_wake_det #(.WAKE_N(WAKE_N)) u_wake (
    .clk(clk), .rst_n(rst_n), .pins(wake_pins), .en(wake_en), .wake_hit(wake_hit)
  );

  wdt_pwr_fsm u_pwr (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .irq(irq),
    .wake_hit(wake_hit), .ovf(cnt_ovf), .halt_enter(halt_enter),
    .halted(halted), .pd_flag(pd_flag), .to_flag(to_flag),
    .wdt_ovf(wdt_ovf), .chip_rst(chip_rst), .warm_rst(warm_rst)
  );

  AST_INSTR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && src == SRC_INSTR && !cnt_clr) |=> $stable(count)); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wdt_en |=> (!wdt_ovf && !chip_rst && !warm_rst)); // R2
  AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_enter |=> (count == '0)); // R6
endmodule

// File: tb/test_wdt_pwr_ctrl.sv
`timescale 1ns/1ps
module test_wdt_pwr_ctrl;
  localparam int PRE_W = 2, CNT_W = 4, WAKE_N = 4;
  localparam int LIMIT = 1 << (PRE_W + CNT_W);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_src = 2'd0;
  logic cfg_wdt_en = 1'b1, cfg_pair_mode = 1'b0;
  logic osc_tick = 0, rtc_tick = 0, instr_tick = 0;
  logic clr_single = 0, clr_a = 0, clr_b = 0, halt_req = 0, irq = 0;
  logic [WAKE_N-1:0] wake_pins = '1, wake_en = '0;
  logic sys_clk_en, halted, pd_flag, to_flag, wdt_ovf, chip_rst, warm_rst;

  int checks = 0, failures = 0;

  // independent cycle model state
  int   m_cnt;
  logic m_sa, m_sb, m_halt, m_pd, m_to, m_ovf, m_chip, m_warm;
  logic [WAKE_N-1:0] m_prev;

  always #5 clk = ~clk;

  wdt_pwr_ctrl #(.PRE_W(PRE_W), .CNT_W(CNT_W), .WAKE_N(WAKE_N)) i_wdt_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_wdt_en(cfg_wdt_en),
    .cfg_pair_mode(cfg_pair_mode), .osc_tick(osc_tick), .rtc_tick(rtc_tick),
    .instr_tick(instr_tick), .clr_single(clr_single), .clr_a(clr_a), .clr_b(clr_b),
    .halt_req(halt_req), .irq(irq), .wake_pins(wake_pins), .wake_en(wake_en),
    .sys_clk_en(sys_clk_en), .halted(halted), .pd_flag(pd_flag), .to_flag(to_flag),
    .wdt_ovf(wdt_ovf), .chip_rst(chip_rst), .warm_rst(warm_rst)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic pick_tick(input logic [1:0] s, input logic h);
    if (s == 2'd0) return osc_tick;
    if (s == 2'd1) return rtc_tick;
    if (s == 2'd2) return instr_tick && !h;
    return 1'b0;
  endfunction

  function automatic logic clear_now(input logic pm, input logic sa, input logic sb);
    if (pm) return (sa || clr_a) && (sb || clr_b);
    return clr_single;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_sa = 0; m_sb = 0; m_halt = 0; m_pd = 0; m_to = 0;
    m_ovf = 0; m_chip = 0; m_warm = 0; m_prev = '1;
  endtask

  task automatic compare(input string tag);
    check(tag, "halted",     halted,     m_halt);
    check(tag, "sys_clk_en", sys_clk_en, !m_halt);
    check(tag, "pd_flag",    pd_flag,    m_pd);
    check(tag, "to_flag",    to_flag,    m_to);
    check(tag, "wdt_ovf",    wdt_ovf,    m_ovf);
    check(tag, "chip_rst",   chip_rst,   m_chip);
    check(tag, "warm_rst",   warm_rst,   m_warm);
  endtask

  // one clock: inputs already applied; model computed from pre-edge values
  task automatic step(input string tag);
    logic tk, done, hent, clr, ov, wake;
    tk   = pick_tick(cfg_src, m_halt);
    done = cfg_pair_mode && (m_sa || clr_a) && (m_sb || clr_b);
    hent = halt_req && !m_halt;
    clr  = clear_now(cfg_pair_mode, m_sa, m_sb) || hent;
    ov   = cfg_wdt_en && !clr && tk && (m_cnt == LIMIT - 1);
    wake = irq || (|(wake_en & m_prev & ~wake_pins));
    @(posedge clk);
    m_ovf = ov; m_chip = ov && !m_halt; m_warm = ov && m_halt;
    if (ov) begin
      m_to = 1; if (!m_halt) m_pd = 0; m_halt = 0;
    end else if (m_halt) begin
      if (wake) m_halt = 0;
    end else if (hent) begin
      m_halt = 1; m_pd = 1; m_to = 0;
    end
    if (!cfg_wdt_en || clr) m_cnt = 0;
    else if (tk) m_cnt = (m_cnt + 1) % LIMIT;
    if (!cfg_pair_mode || done) begin m_sa = 0; m_sb = 0; end
    else begin m_sa = m_sa || clr_a; m_sb = m_sb || clr_b; end
    m_prev = wake_pins;
    #1;
    compare(tag);
  endtask

  task automatic idle_inputs();
    osc_tick = 0; rtc_tick = 0; instr_tick = 0; clr_single = 0; clr_a = 0;
    clr_b = 0; halt_req = 0; irq = 0;
  endtask

  task automatic do_reset(input logic [1:0] s, input logic en, input logic pm);
    idle_inputs();
    wake_pins = '1;
    cfg_src = s; cfg_wdt_en = en; cfg_pair_mode = pm;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1;
    model_reset();
    compare("R11");
    rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));

    // R11: reset state, then R3/R8: overflow after LIMIT ticks in run mode
    do_reset(2'd0, 1'b1, 1'b0);
    osc_tick = 1;
    for (int i = 1; i <= LIMIT; i++) begin
      step("R3");
      check("R3", "ovf timing", wdt_ovf, (i == LIMIT));
    end
    check("R8", "chip_rst after run overflow", chip_rst, 1'b1);
    check("R8", "to_flag after run overflow", to_flag, 1'b1);

    // R12: clear on the final tick wins
    do_reset(2'd0, 1'b1, 1'b0);
    osc_tick = 1;
    for (int i = 1; i <= 2 * LIMIT; i++) begin
      clr_single = (i == LIMIT);
      step("R12");
      if (i == LIMIT) check("R12", "no ovf when clear meets last tick", wdt_ovf, 1'b0);
    end
    check("R12", "ovf one window after clear", wdt_ovf, 1'b1);

    // R5: repeated clr_a alone does not clear; R4-style single ignored in pair mode
    do_reset(2'd0, 1'b1, 1'b1);
    osc_tick = 1;
    for (int i = 1; i <= LIMIT; i++) begin
      clr_a = (i == 10 || i == 20);
      clr_single = (i == 30);
      step("R5");
    end
    check("R5", "ovf despite lone A and single", wdt_ovf, 1'b1);
    clr_a = 0; clr_single = 0;

    // R5: pair A then B clears, then A again alone does not
    do_reset(2'd0, 1'b1, 1'b1);
    osc_tick = 1;
    for (int i = 1; i <= 40 + LIMIT; i++) begin
      clr_a = (i == 30 || i == 45);
      clr_b = (i == 40);
      step("R5");
    end
    check("R5", "ovf one window after pair", wdt_ovf, 1'b1);
    idle_inputs();

    // R4: pair commands ignored in single mode
    do_reset(2'd1, 1'b1, 1'b0);
    rtc_tick = 1;
    for (int i = 1; i <= LIMIT; i++) begin
      clr_a = 1; clr_b = 1;
      step("R4");
    end
    check("R4", "ovf despite A and B in single mode", wdt_ovf, 1'b1);
    idle_inputs();

    // R6/R9: halt, keep oscillator ticking, warm reset ends halt
    do_reset(2'd0, 1'b1, 1'b0);
    halt_req = 1; step("R6"); halt_req = 0;
    check("R6", "halted", halted, 1'b1);
    check("R7", "sys_clk_en low", sys_clk_en, 1'b0);
    osc_tick = 1;
    for (int i = 1; i <= LIMIT; i++) step("R9");
    check("R9", "warm_rst", warm_rst, 1'b1);
    check("R9", "pd kept", pd_flag, 1'b1);
    check("R9", "halt left", halted, 1'b0);
    idle_inputs();

    // R7: instruction source frozen while halted; R10 wake by enabled pin only
    do_reset(2'd2, 1'b1, 1'b0);
    wake_en = 4'b0010;
    halt_req = 1; step("R6"); halt_req = 0;
    instr_tick = 1;
    for (int i = 0; i < 2 * LIMIT; i++) step("R7");
    check("R7", "still halted, no ovf from instr", halted, 1'b1);
    wake_pins = 4'b1110; step("R10");
    check("R10", "disabled pin ignored", halted, 1'b1);
    wake_pins = 4'b1100; step("R10");
    check("R10", "enabled pin falling wakes", halted, 1'b0);
    idle_inputs();
    halt_req = 1; step("R6"); halt_req = 0;
    irq = 1; step("R10"); irq = 0;
    check("R10", "irq wakes", halted, 1'b0);

    // R2: disabled watchdog stays silent
    do_reset(2'd0, 1'b0, 1'b0);
    osc_tick = 1;
    for (int i = 0; i < 3 * LIMIT; i++) step("R2");
    check("R2", "no ovf when disabled", to_flag, 1'b0);
    idle_inputs();

    // random phases across all configurations: R1 R2 R4 R5 R6 R7 R8 R9 R10
    for (int ph = 0; ph < 16; ph++) begin
      do_reset(ph[1:0], (ph % 7) != 6, ph[2]);
      wake_en = $urandom_range(15, 0);
      for (int c = 0; c < 2500; c++) begin
        osc_tick   = ($urandom_range(1, 0) == 0);
        rtc_tick   = ($urandom_range(2, 0) == 0);
        instr_tick = ($urandom_range(1, 0) == 0);
        clr_single = ($urandom_range(149, 0) == 0);
        clr_a      = ($urandom_range(79, 0) == 0);
        clr_b      = ($urandom_range(79, 0) == 0);
        halt_req   = ($urandom_range(59, 0) == 0);
        irq        = ($urandom_range(119, 0) == 0);
        for (int p = 0; p < WAKE_N; p++)
          if ($urandom_range(29, 0) == 0) wake_pins[p] = ~wake_pins[p];
        step("R1");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule